// File: doc/BRIEF.md
# Keyed Slot Stack

This block holds a fixed array of configuration slots, each 16 bits wide. The low five bits of every slot are the slot's key. One command updates the array. It carries a value, a flag that selects the top end or the bottom end, and the active length. The block picks one of four actions from these inputs and from what the array already holds:

- replace a slot in place when its key matches;
- push at the top;
- push at the bottom;
- pop one slot.

Every command returns, one cycle later, the slot that was evicted or removed, or zero when nothing left the array. The whole array is exposed as one flat output, so lookup logic downstream can read all slots at once.

The occupied region starts at slot 0. It runs up to the first zero slot below the active length. It fills the whole active length when no such zero slot exists. Slots at or above the active length take no part in a command.

Top module: `keyed_slot_stack`

## Requirements
- R1: While `rst` is high, every slot is cleared to zero at each clock edge and `resp_valid` is low.
- R2: A command sampled at a rising edge updates `table_flat` at that same edge, and it drives `resp_valid` high with `resp_value` for exactly the following cycle. Without a command, `table_flat` holds its value and `resp_valid` stays low.
- R3: A nonzero value whose key (bits 4:0) is nonzero overwrites the lowest occupied slot that has the same key, and returns 0. A slot above the first zero slot never matches.
- R4: A zero value with the top end selected clears the highest occupied slot and returns its old content.
- R5: A zero value with the bottom end selected returns slot 0, moves every other occupied slot down by one index, and clears the old highest occupied slot.
- R6: A zero value on an empty array (slot 0 is zero) returns 0 and leaves every slot unchanged.
- R7: A top push with a free slot below the active length writes the value into the first zero slot and returns 0.
- R8: A top push when every slot below the active length is occupied returns slot 0, moves slots 1..L-1 down by one, and writes the value into slot L-1, where L is the effective length.
- R9: A bottom push moves the occupied slots up by one and writes the value into slot 0. It returns the old slot L-1 when the region was full, and 0 otherwise.
- R10: An active length above the depth counts as the depth. A length of 0 leaves the array unchanged and returns 0. Slots at or above the effective length never change.
- R11: A nonzero value with key 0 never matches any slot, so it is always pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_value | input | ENTRY_W (16) | Entry to write; zero requests a pop |
| cmd_at_top | input | 1 | 1 selects the top end, 0 the bottom end |
| cmd_len | input | $clog2(DEPTH+1) (5) | Active length |
| resp_valid | output | 1 | Response strobe, one cycle after a command |
| resp_value | output | ENTRY_W (16) | Evicted or removed entry, or 0 |
| table_flat | output | DEPTH*ENTRY_W (256) | All slots; slot i sits at bits i*ENTRY_W +: ENTRY_W |

## Verification
A command that is applied before edge k has its effects visible after edge k. At that point the new slot contents and the response value both appear, and `resp_valid` is high for that one cycle only. The bench queues the expected response and the expected array at the moment it drives a command. The monitor samples at the next falling edge, one cycle after the command was driven, and compares each queued item with the design's output.

Commands are issued back to back, so this one-cycle latency is checked under a full load. Idle stretches check that the array does not change and that no response strobe appears.

// File: rtl/kss_pkg.sv
package kss_pkg;
  parameter int KEY_W = 5;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_REPLACE,
    OP_POP_TOP,
    OP_POP_BOT,
    OP_PUSH_TOP,
    OP_PUSH_BOT
  } op_e;
endpackage

// File: rtl/kss_scan.sv
module kss_scan
  import kss_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int LEN_W   = $clog2(DEPTH + 1),
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][ENTRY_W-1:0] slots,
  input  logic [ENTRY_W-1:0]            value,
  input  logic                          at_top,
  input  logic [LEN_W-1:0]              len_eff,
  output op_e                           op,
  output logic [LEN_W-1:0]              used_cnt,
  output logic                          full,
  output logic [IDX_W-1:0]              hit_idx
);
  logic             seen;
  logic             hit;
  logic [KEY_W-1:0] key;

  assign key = value[KEY_W-1:0];

  // occupied count: index of the first zero slot inside the active length
  always_comb begin
    used_cnt = len_eff;
    seen     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!seen && (LEN_W'(i) < len_eff) && (slots[i] == '0)) begin
        used_cnt = LEN_W'(i);
        seen     = 1'b1;
      end
    end
  end

  // lowest occupied slot carrying the same nonzero key
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit && (LEN_W'(i) < used_cnt) && (key != '0) &&
          (slots[i][KEY_W-1:0] == key)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign full = (used_cnt == len_eff);

  always_comb begin
    if (len_eff == '0)
      op = OP_HOLD;
    else if (value == '0)
      op = (used_cnt == '0) ? OP_HOLD : (at_top ? OP_POP_TOP : OP_POP_BOT);
    else if (hit)
      op = OP_REPLACE;
    else
      op = at_top ? OP_PUSH_TOP : OP_PUSH_BOT;
  end
endmodule

// File: rtl/kss_update.sv
module kss_update
  import kss_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int LEN_W   = $clog2(DEPTH + 1),
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][ENTRY_W-1:0] slots,
  input  logic [ENTRY_W-1:0]            value,
  input  op_e                           op,
  input  logic [LEN_W-1:0]              used_cnt,
  input  logic [LEN_W-1:0]              len_eff,
  input  logic                          full,
  input  logic [IDX_W-1:0]              hit_idx,
  output logic [DEPTH-1:0][ENTRY_W-1:0] next_slots,
  output logic [ENTRY_W-1:0]            resp_next
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [LEN_W-1:0] I  = LEN_W'(g);
    localparam logic [LEN_W-1:0] I1 = LEN_W'(g + 1);
    logic [ENTRY_W-1:0] above;
    logic [ENTRY_W-1:0] below;

    if (g < DEPTH - 1) begin : g_up
      assign above = slots[g+1];
    end else begin : g_up_none
      assign above = '0;
    end

    if (g > 0) begin : g_dn
      assign below = slots[g-1];
    end else begin : g_dn_none
      assign below = '0;
    end

    always_comb begin
      next_slots[g] = slots[g];
      unique case (op)
        OP_REPLACE:
          if (hit_idx == IDX_W'(g)) next_slots[g] = value;
        OP_POP_TOP:
          if (I1 == used_cnt) next_slots[g] = '0;
        OP_POP_BOT:
          if (I1 < used_cnt)       next_slots[g] = above;
          else if (I1 == used_cnt) next_slots[g] = '0;
        OP_PUSH_TOP:
          if (full) begin
            if (I1 < len_eff)       next_slots[g] = above;
            else if (I1 == len_eff) next_slots[g] = value;
          end else if (I == used_cnt) begin
            next_slots[g] = value;
          end
        OP_PUSH_BOT:
          if (g == 0)                                next_slots[g] = value;
          else if ((I <= used_cnt) && (I < len_eff)) next_slots[g] = below;
        default: ;
      endcase
    end
  end

  always_comb begin
    resp_next = '0;
    unique case (op)
      OP_POP_TOP:
        for (int i = 0; i < DEPTH; i++)
          if (LEN_W'(i + 1) == used_cnt) resp_next = slots[i];
      OP_POP_BOT:
        resp_next = slots[0];
      OP_PUSH_TOP:
        if (full) resp_next = slots[0];
      OP_PUSH_BOT:
        if (full)
          for (int i = 0; i < DEPTH; i++)
            if (LEN_W'(i + 1) == len_eff) resp_next = slots[i];
      default: ;
    endcase
  end
endmodule

// File: rtl/keyed_slot_stack.sv
module keyed_slot_stack
  import kss_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [ENTRY_W-1:0]         cmd_value,
  input  logic                       cmd_at_top,
  input  logic [LEN_W-1:0]           cmd_len,
  output logic                       resp_valid,
  output logic [ENTRY_W-1:0]         resp_value,
  output logic [DEPTH*ENTRY_W-1:0]   table_flat
);
  logic [DEPTH-1:0][ENTRY_W-1:0] slots_q;
  logic [DEPTH-1:0][ENTRY_W-1:0] slots_d;
  logic [ENTRY_W-1:0]            resp_d;
  logic [LEN_W-1:0]              len_eff;
  logic [LEN_W-1:0]              used_cnt;
  logic                          full;
  logic [IDX_W-1:0]              hit_idx;
  op_e                           op;

  assign len_eff = (cmd_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cmd_len;

  kss_scan #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_scan (
    .slots    (slots_q),
    .value    (cmd_value),
    .at_top   (cmd_at_top),
    .len_eff  (len_eff),
    .op       (op),
    .used_cnt (used_cnt),
    .full     (full),
    .hit_idx  (hit_idx)
  );

  kss_update #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_update (
    .slots      (slots_q),
    .value      (cmd_value),
    .op         (op),
    .used_cnt   (used_cnt),
    .len_eff    (len_eff),
    .full       (full),
    .hit_idx    (hit_idx),
    .next_slots (slots_d),
    .resp_next  (resp_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q    <= '0;
      resp_valid <= 1'b0;
      resp_value <= '0;
    end else begin
      resp_valid <= cmd_valid;
      if (cmd_valid) begin
        slots_q    <= slots_d;
        resp_value <= resp_d;
      end
    end
  end

  assign table_flat = slots_q;
endmodule

// File: rtl/keyed_slot_stack_chk.sv
module keyed_slot_stack_chk #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int LEN_W   = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic [ENTRY_W-1:0]       cmd_value,
  input logic                     cmd_at_top,
  input logic [LEN_W-1:0]         cmd_len,
  input logic                     resp_valid,
  input logic [ENTRY_W-1:0]       resp_value,
  input logic [DEPTH*ENTRY_W-1:0] table_flat
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (table_flat == '0) && !resp_valid);

  p_resp_follows_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> resp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !resp_valid && $stable(table_flat));

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_value == '0) && (table_flat[ENTRY_W-1:0] == '0)
    |=> (resp_value == '0) && $stable(table_flat));

  p_zero_len_inert_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_len == '0) |=> (resp_value == '0) && $stable(table_flat));

  // R9 and R11: a keyless nonzero value pushed at the bottom lands in slot 0
  p_bottom_push_lands_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_value != '0) && !cmd_at_top && (cmd_len != '0) &&
    (cmd_value[4:0] == 5'd0)
    |=> table_flat[ENTRY_W-1:0] == $past(cmd_value));
endmodule

bind keyed_slot_stack keyed_slot_stack_chk #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_value  (cmd_value),
  .cmd_at_top (cmd_at_top),
  .cmd_len    (cmd_len),
  .resp_valid (resp_valid),
  .resp_value (resp_value),
  .table_flat (table_flat)
);

// File: tb/keyed_slot_stack_test.sv
module keyed_slot_stack_test;
  localparam int DEPTH   = 16;
  localparam int ENTRY_W = 16;
  localparam int LEN_W   = $clog2(DEPTH + 1);
  localparam int FW      = DEPTH * ENTRY_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cmd_valid = 1'b0;
  logic [ENTRY_W-1:0] cmd_value = '0;
  logic               cmd_at_top = 1'b0;
  logic [LEN_W-1:0]   cmd_len = '0;
  logic               resp_valid;
  logic [ENTRY_W-1:0] resp_value;
  logic [FW-1:0]      table_flat;

  int checks = 0;
  int fails  = 0;

  logic [ENTRY_W-1:0] mdl [DEPTH];
  logic [ENTRY_W-1:0] exp_resp_q [$];
  logic [FW-1:0]      exp_tab_q  [$];
  string              tag_q      [$];

  always #2 clk = ~clk;

  keyed_slot_stack #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_value(cmd_value),
    .cmd_at_top(cmd_at_top), .cmd_len(cmd_len), .resp_valid(resp_valid),
    .resp_value(resp_value), .table_flat(table_flat)
  );

  function automatic logic [FW-1:0] flat_model();
    logic [FW-1:0] f;
    for (int i = 0; i < DEPTH; i++) f[i*ENTRY_W +: ENTRY_W] = mdl[i];
    return f;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: occupied region treated as a list
  function automatic logic [ENTRY_W-1:0] apply(input logic [ENTRY_W-1:0] v,
                                               input bit top, input int len_in);
    logic [ENTRY_W-1:0] q [$];
    logic [ENTRY_W-1:0] ret = '0;
    int len = (len_in > DEPTH) ? DEPTH : len_in;
    int cnt = len;
    bit hit = 0;
    if (len == 0) return '0;
    for (int i = len - 1; i >= 0; i--) if (mdl[i] == '0) cnt = i;
    for (int i = 0; i < cnt; i++) q.push_back(mdl[i]);
    if (v == '0) begin
      if (cnt == 0) return '0;
      ret = top ? q.pop_back() : q.pop_front();
    end else begin
      for (int i = 0; i < q.size(); i++)
        if (!hit && v[4:0] != 5'd0 && q[i][4:0] == v[4:0]) begin
          q[i] = v;
          hit = 1;
        end
      if (!hit) begin
        if (top) begin
          if (cnt == len) ret = q.pop_front();
          q.push_back(v);
        end else begin
          if (cnt == len) ret = q.pop_back();
          q.push_front(v);
        end
      end
    end
    for (int i = 0; i < len; i++)
      if (i < q.size()) mdl[i] = q[i];
      else if (i < cnt) mdl[i] = '0;
    return ret;
  endfunction

  task automatic issue(input logic [ENTRY_W-1:0] v, input bit top, input int len,
                       input string tag);
    @(negedge clk);
    exp_resp_q.push_back(apply(v, top, len));
    exp_tab_q.push_back(flat_model());
    tag_q.push_back(tag);
    cmd_valid  = 1'b1;
    cmd_value  = v;
    cmd_at_top = top;
    cmd_len    = LEN_W'(len);
  endtask

  task automatic go_idle(input int n, input string tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
    check(table_flat == flat_model(), {tag, " table held"}, table_flat, flat_model());
    check(resp_valid == 1'b0, {tag, " no strobe"}, FW'(resp_valid), '0);
  endtask

  // monitor: one response is due one cycle after each command
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_resp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", FW'(resp_value), '0);
      end else begin
        logic [ENTRY_W-1:0] er;
        logic [FW-1:0]      et;
        string              tg;
        er = exp_resp_q.pop_front();
        et = exp_tab_q.pop_front();
        tg = tag_q.pop_front();
        check(resp_value == er, {tg, " response"}, FW'(resp_value), FW'(er));
        check(table_flat == et, {tg, " table"}, table_flat, et);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check(table_flat == '0, "R1 reset table", table_flat, '0);
    check(resp_valid == 1'b0, "R1 reset strobe", FW'(resp_valid), '0);
    rst = 1'b0;

    issue(16'h0000, 1, 16, "R6 pop top empty");
    issue(16'h0000, 0, 16, "R6 pop bottom empty");
    issue(16'h0101, 1, 16, "R7 push top");
    issue(16'h0202, 1, 16, "R7 push top");
    issue(16'h0303, 1, 16, "R7 push top");
    issue(16'h1A02, 1, 16, "R3 replace key 2");
    issue(16'h0400, 1, 16, "R11 key zero pushes");
    issue(16'h0500, 1, 16, "R11 key zero pushes again");
    issue(16'h0000, 1, 16, "R4 pop top");
    issue(16'h0606, 0, 16, "R9 push bottom not full");
    issue(16'h0000, 0, 16, "R5 pop bottom");
    go_idle(3, "R2 idle");

    issue(16'h0707, 1, 4, "R8 push top full");
    issue(16'h0808, 0, 4, "R9 push bottom full");
    issue(16'h0909, 1, 0, "R10 zero length");
    for (int k = 9; k <= 20; k++)
      issue(16'((k << 8) | k), 1, 20, "R10 length above depth");
    issue(16'h0015, 1, 31, "R8 push top full at depth");
    issue(16'h0000, 1, 8, "R10 pop top short length");
    issue(16'h550E, 1, 16, "R3 key above first zero not matched");
    issue(16'h770E, 1, 16, "R3 lowest key match replaced");
    issue(16'h0000, 0, 16, "R5 pop bottom full");
    issue(16'h0900, 0, 5, "R9 bottom push keyless short length");
    go_idle(2, "R2 final idle");

    check(exp_resp_q.size() == 0, "R2 all responses seen",
          FW'(exp_resp_q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule